// File: doc/BRIEF.md
# PHY Calibration Write Sequencer

This block tunes a high-speed serial PHY after start-up. On a calibrate request it issues three override writes into the PHY's internal control port, always in the same order. The writes set the loss-of-signal detector level, the transmit boost level and the receiver-detect measurement time. Each write goes out through a separate write-master block, using an address, a data word, a start pulse and a done strobe that carries an error flag.

The measurement-time payload depends on the PHY reference clock. A 3-bit reference code is captured when a request is accepted, so later changes on that input cannot alter a sequence that is already running. The first write that reports an error stops the sequence. A one-cycle completion pulse is then raised together with a failure flag, and the index of the failing write is held on an output until the next request is accepted.

Top module: `phy_cal_seq`

## Requirements
- R1: When idle, a high `cal_req` is accepted at a clock edge. In the next cycle `cal_busy` and `wr_start` are high, with `wr_addr` = 0x0015 and `wr_data` = 0xA409 (bias 5 at bit 13, override enable at bit 10, level 9).
- R2: In the cycle after the first write's successful done is sampled, the second write starts with address 0x0012 and data 0xA000 (boost 5 at bit 13).
- R3: In the cycle after the second write's successful done is sampled, the third write starts with address 0x1010. Its data holds the measurement field at bit 4: 0x20 for reference code 3 (50 MHz), 0x04 for codes 0 (19.2 MHz) and 1 (20 MHz), and 0x08 for code 2 (24 MHz) and for every unlisted code (4 to 7).
- R4: The reference code is captured when the request is accepted. Changes on `ref_sel` during a sequence have no effect on the third write's data.
- R5: If `wr_err` is high with a sampled done, no further write starts. In the next cycle `cal_done` and `cal_fail` are both high for one cycle, and `fail_step` shows the failing write's index (0, 1 or 2). This also applies when the third write fails.
- R6: After the third write's done is sampled without error, the next cycle shows a one-cycle `cal_done` with `cal_fail` low, `cal_busy` low, and `fail_step` = 3 (no failure).
- R7: A `cal_req` while `cal_busy` is high is ignored. This includes a request in the same cycle as the final write's done: no write is restarted, and each sequence issues its writes exactly once.
- R8: During and after reset, `cal_busy`, `wr_start`, `cal_done` and `cal_fail` are low, `wr_addr` and `wr_data` are zero, and `fail_step` = 3.
- R9: A `wr_done` while idle, or in the same cycle as `wr_start`, is ignored.
- R10: `wr_start` is high for exactly one cycle per write, and `wr_addr`/`wr_data` hold steady from that start until the next write starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Calibrate request, sampled when idle |
| ref_sel | input | 3 | Reference clock code: 0=19.2 MHz, 1=20 MHz, 2=24 MHz, 3=50 MHz |
| wr_addr | output | 16 | Control-port address of the current write |
| wr_data | output | 16 | Control-port data of the current write |
| wr_start | output | 1 | One-cycle start of a write |
| wr_done | input | 1 | Write-master completion strobe |
| wr_err | input | 1 | Error flag, valid with `wr_done` |
| cal_busy | output | 1 | High while a sequence runs |
| cal_done | output | 1 | One-cycle end-of-sequence pulse |
| cal_fail | output | 1 | High with `cal_done` when a write failed |
| fail_step | output | 2 | Index of the failing write, 3 when none failed |

## Verification
Two events can land on the same clock edge: a new calibrate request and the completion of the last write. The bench raises `cal_req` together with that final `wr_done` and expects it to be ignored, so that no extra write follows and the completion pulse appears alone. In other runs it raises `cal_req` in the very cycle the completion pulse is visible and expects an immediate, clean restart at the first address. A done strobe placed in the same cycle as a start pulse is also provoked, and it must not advance the sequence.

// File: rtl/phy_cal_pkg.sv
package phy_cal_pkg;

    localparam int CAL_STEPS  = 3;
    localparam int STEP_W     = 2;
    localparam int MEAS_STEP  = 2;
    localparam int MEAS_LSB   = 4;
    localparam int MEAS_W     = 7;
    localparam int CODE_W     = 3;

    localparam logic [STEP_W-1:0] STEP_NONE = 2'd3;
    localparam logic [STEP_W-1:0] STEP_LAST = 2'(CAL_STEPS - 1);

    localparam logic [CODE_W-1:0] REF_19M2 = 3'd0;
    localparam logic [CODE_W-1:0] REF_20M  = 3'd1;
    localparam logic [CODE_W-1:0] REF_24M  = 3'd2;
    localparam logic [CODE_W-1:0] REF_50M  = 3'd3;

    localparam logic [MEAS_W-1:0] MEAS_SLOW = 7'h04;
    localparam logic [MEAS_W-1:0] MEAS_MID  = 7'h08;
    localparam logic [MEAS_W-1:0] MEAS_FAST = 7'h20;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    function automatic logic [15:0] step_addr(input int idx);
        case (idx)
            0:       return 16'h0015;
            1:       return 16'h0012;
            default: return 16'h1010;
        endcase
    endfunction

    function automatic logic [15:0] step_fixed_data(input int idx);
        case (idx)
            0:       return (16'd5 << 13) | (16'd1 << 10) | 16'd9;
            1:       return 16'd5 << 13;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/phy_cal_meas_sel.sv
module phy_cal_meas_sel
    import phy_cal_pkg::*;
#(
    parameter int REF_W = 3
) (
    input  logic [REF_W-1:0]  ref_code,
    output logic [MEAS_W-1:0] meas
);

    always_comb begin
        case (ref_code)
            REF_W'(REF_50M):                  meas = MEAS_FAST;
            REF_W'(REF_19M2), REF_W'(REF_20M): meas = MEAS_SLOW;
            REF_W'(REF_24M):                  meas = MEAS_MID;
            default:                          meas = MEAS_MID;
        endcase
    end

endmodule

// File: rtl/phy_cal_payload.sv
module phy_cal_payload
    import phy_cal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int REF_W  = 3
) (
    input  logic [STEP_W-1:0] step,
    input  logic [REF_W-1:0]  ref_code,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    logic [MEAS_W-1:0] meas;
    logic [ADDR_W-1:0] addr_tbl [CAL_STEPS];
    logic [DATA_W-1:0] data_tbl [CAL_STEPS];

    phy_cal_meas_sel #(.REF_W(REF_W)) u_meas (
        .ref_code (ref_code),
        .meas     (meas)
    );

    for (genvar g = 0; g < CAL_STEPS; g++) begin : g_step
        assign addr_tbl[g] = ADDR_W'(step_addr(g));
        if (g == MEAS_STEP) begin : g_meas
            assign data_tbl[g] = DATA_W'(meas) << MEAS_LSB;
        end else begin : g_fixed
            assign data_tbl[g] = DATA_W'(step_fixed_data(g));
        end
    end

    always_comb begin
        addr = '0;
        data = '0;
        if (int'(step) < CAL_STEPS) begin
            addr = addr_tbl[step];
            data = data_tbl[step];
        end
    end

endmodule

// File: rtl/phy_cal_ctrl.sv
module phy_cal_ctrl
    import phy_cal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int REF_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic [REF_W-1:0]  ref_sel,
    input  logic              wr_done,
    input  logic              wr_err,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic [DATA_W-1:0] pl_data,
    output logic [STEP_W-1:0] pl_step,
    output logic [REF_W-1:0]  pl_ref,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_start,
    output logic              cal_busy,
    output logic              cal_done,
    output logic              cal_fail,
    output logic [STEP_W-1:0] fail_step
);

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic [REF_W-1:0]  ref_code;
        logic              start;
        logic              done;
        logic              fail;
        logic [STEP_W-1:0] fail_step;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic  done_seen;

    assign done_seen = wr_done && !r_q.start;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.done  = 1'b0;
        r_d.fail  = 1'b0;
        pl_step   = r_q.step;
        pl_ref    = r_q.ref_code;
        case (r_q.state)
            ST_IDLE: begin
                if (cal_req) begin
                    pl_step       = '0;
                    pl_ref        = ref_sel;
                    r_d.state     = ST_RUN;
                    r_d.step      = '0;
                    r_d.ref_code  = ref_sel;
                    r_d.start     = 1'b1;
                    r_d.fail_step = STEP_NONE;
                    r_d.addr      = pl_addr;
                    r_d.data      = pl_data;
                end
            end
            ST_RUN: begin
                if (done_seen) begin
                    if (wr_err) begin
                        r_d.state     = ST_IDLE;
                        r_d.done      = 1'b1;
                        r_d.fail      = 1'b1;
                        r_d.fail_step = r_q.step;
                    end else if (r_q.step == STEP_LAST) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        pl_step   = r_q.step + 1'b1;
                        r_d.step  = r_q.step + 1'b1;
                        r_d.start = 1'b1;
                        r_d.addr  = pl_addr;
                        r_d.data  = pl_data;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.state     <= ST_IDLE;
            r_q.fail_step <= STEP_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_addr   = r_q.addr;
    assign wr_data   = r_q.data;
    assign wr_start  = r_q.start;
    assign cal_busy  = (r_q.state == ST_RUN);
    assign cal_done  = r_q.done;
    assign cal_fail  = r_q.fail;
    assign fail_step = r_q.fail_step;

endmodule

// File: rtl/phy_cal_seq.sv
module phy_cal_seq
    import phy_cal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int REF_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic [REF_W-1:0]  ref_sel,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_start,
    input  logic              wr_done,
    input  logic              wr_err,
    output logic              cal_busy,
    output logic              cal_done,
    output logic              cal_fail,
    output logic [1:0]        fail_step
);

    logic [STEP_W-1:0] pl_step;
    logic [REF_W-1:0]  pl_ref;
    logic [ADDR_W-1:0] pl_addr;
    logic [DATA_W-1:0] pl_data;

    phy_cal_payload #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REF_W  (REF_W)
    ) u_payload (
        .step     (pl_step),
        .ref_code (pl_ref),
        .addr     (pl_addr),
        .data     (pl_data)
    );

    phy_cal_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REF_W  (REF_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_req   (cal_req),
        .ref_sel   (ref_sel),
        .wr_done   (wr_done),
        .wr_err    (wr_err),
        .pl_addr   (pl_addr),
        .pl_data   (pl_data),
        .pl_step   (pl_step),
        .pl_ref    (pl_ref),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_start  (wr_start),
        .cal_busy  (cal_busy),
        .cal_done  (cal_done),
        .cal_fail  (cal_fail),
        .fail_step (fail_step)
    );

endmodule

// File: rtl/phy_cal_seq_chk.sv
module phy_cal_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_start,
    input logic              cal_busy,
    input logic              cal_done,
    input logic              cal_fail,
    input logic [1:0]        fail_step
);

    localparam logic [ADDR_W-1:0] FIRST_ADDR = ADDR_W'(16'h0015);

    // R1: a sequence opens with the level-override write
    a_r1_first_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_busy) |-> (wr_start && wr_addr == FIRST_ADDR));

    // R10: start lasts one cycle
    a_r10_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);

    // R10: payload steady between starts
    a_r10_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && !wr_start) |-> ($stable(wr_addr) && $stable(wr_data)));

    // R6: completion is a single-cycle pulse outside busy
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !cal_busy);

    a_r6_ok_index: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !cal_fail) |-> (fail_step == 2'd3));

    // R5: failure only accompanies completion and names a real write
    a_r5_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fail |-> (cal_done && fail_step != 2'd3 && !wr_start));

    // R7: a request while busy never restarts the sequence
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && cal_req) |=> !(wr_start && wr_addr == FIRST_ADDR));

endmodule

bind phy_cal_seq phy_cal_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_req   (cal_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_start  (wr_start),
    .cal_busy  (cal_busy),
    .cal_done  (cal_done),
    .cal_fail  (cal_fail),
    .fail_step (fail_step)
);

// File: tb/phy_cal_seq_tb_top.sv
module phy_cal_seq_tb_top;

    localparam time CLK_P  = 10ns;
    localparam int  WD_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_req = 1'b0;
    logic [2:0]  ref_sel = 3'd0;
    logic [15:0] wr_addr;
    logic [15:0] wr_data;
    logic        wr_start;
    logic        wr_done = 1'b0;
    logic        wr_err = 1'b0;
    logic        cal_busy;
    logic        cal_done;
    logic        cal_fail;
    logic [1:0]  fail_step;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    phy_cal_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_req   (cal_req),
        .ref_sel   (ref_sel),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_start  (wr_start),
        .wr_done   (wr_done),
        .wr_err    (wr_err),
        .cal_busy  (cal_busy),
        .cal_done  (cal_done),
        .cal_fail  (cal_fail),
        .fail_step (fail_step)
    );

    function automatic logic [15:0] exp_addr(input int k);
        return (k == 0) ? 16'h0015 : (k == 1) ? 16'h0012 : 16'h1010;
    endfunction

    function automatic logic [15:0] exp_data(input int k, input logic [2:0] rf);
        logic [15:0] m;
        if (k == 0) return 16'hA409;
        if (k == 1) return 16'hA000;
        case (rf)
            3'd3:       m = 16'h20;
            3'd0, 3'd1: m = 16'h04;
            default:    m = 16'h08;
        endcase
        return m << 4;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic request(input logic [2:0] rf);
        cal_req = 1'b1;
        ref_sel = rf;
        @(negedge clk);
        cal_req = 1'b0;
        ref_sel = 3'($urandom);
    endtask

    // Entered at the negedge where the first start is visible.
    task automatic seq_body(input logic [2:0] rf, input int fail_at, input bit poke,
                            input bit glitch, input bit chain, input logic [2:0] nref);
        int last;
        int lat;
        last = (fail_at < 3) ? fail_at : 2;
        for (int k = 0; k <= last; k++) begin
            chk(wr_start === 1'b1 && cal_busy === 1'b1, "R10 start visible", {30'd0, cal_busy, wr_start}, 32'h3);
            chk(wr_addr === exp_addr(k), (k == 0) ? "R1 addr" : (k == 1) ? "R2 addr" : "R3 addr",
                wr_addr, exp_addr(k));
            chk(wr_data === exp_data(k, rf), (k == 0) ? "R1 data" : (k == 1) ? "R2 data" : "R3/R4 data",
                wr_data, exp_data(k, rf));
            lat = 2 + int'($urandom % 3);
            if (glitch && k == 0) begin
                wr_done = 1'b1;
                @(negedge clk);
                wr_done = 1'b0;
                chk(wr_start === 1'b0 && wr_addr === exp_addr(0), "R9 done in start cycle", wr_addr, exp_addr(0));
            end
            for (int i = 1; i < lat; i++) begin
                @(negedge clk);
                ref_sel = 3'($urandom);
                chk(wr_start === 1'b0, "R10 single pulse", wr_start, 0);
                chk(wr_addr === exp_addr(k) && wr_data === exp_data(k, rf), "R10 hold", wr_addr, exp_addr(k));
            end
            wr_done = 1'b1;
            wr_err  = (k == fail_at);
            cal_req = poke;
            @(negedge clk);
            wr_done = 1'b0;
            wr_err  = 1'b0;
            cal_req = 1'b0;
        end
        chk(cal_done === 1'b1, "R5/R6 done pulse", cal_done, 1);
        chk(cal_fail === (fail_at < 3), "R5/R6 fail flag", cal_fail, (fail_at < 3));
        chk(fail_step === ((fail_at < 3) ? 2'(fail_at) : 2'd3), "R5/R6 fail_step", fail_step,
            (fail_at < 3) ? fail_at : 3);
        chk(cal_busy === 1'b0, "R6 idle at done", cal_busy, 0);
        if (chain) begin
            request(nref);
        end else begin
            @(negedge clk);
            chk(cal_done === 1'b0, "R6 one cycle", cal_done, 0);
            chk(wr_start === 1'b0 && cal_busy === 1'b0, "R7/R5 no restart", {30'd0, cal_busy, wr_start}, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h0C41_5EED));
        #(CLK_P * 3);
        // R8: reset values
        chk(cal_busy === 0 && wr_start === 0 && cal_done === 0 && cal_fail === 0,
            "R8 reset controls", {28'd0, cal_busy, wr_start, cal_done, cal_fail}, 0);
        chk(wr_addr === 0 && wr_data === 0, "R8 reset payload", {wr_addr, wr_data}, 0);
        chk(fail_step === 2'd3, "R8 reset fail_step", fail_step, 3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: stray done while idle
        wr_done = 1'b1;
        wr_err  = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
        wr_err  = 1'b0;
        @(negedge clk);
        chk(cal_busy === 0 && wr_start === 0 && cal_done === 0, "R9 idle done ignored",
            {29'd0, cal_busy, wr_start, cal_done}, 0);

        // Directed: every reference code, clean runs (R3, R6)
        for (int r = 0; r < 8; r++) begin
            request(3'(r));
            seq_body(3'(r), 3, 1'b0, 1'b0, 1'b0, 3'd0);
        end
        // Failure at each write (R5), including the last
        for (int f = 0; f < 3; f++) begin
            request(3'd3);
            seq_body(3'd3, f, 1'b1, 1'b0, 1'b0, 3'd0);
        end
        // Done in the start cycle (R9), then request with the final done (R7)
        request(3'd1);
        seq_body(3'd1, 3, 1'b1, 1'b1, 1'b0, 3'd0);
        // Back-to-back: request in the done cycle is accepted (R1)
        request(3'd0);
        seq_body(3'd0, 3, 1'b0, 1'b0, 1'b1, 3'd3);
        seq_body(3'd3, 3, 1'b0, 1'b0, 1'b0, 3'd0);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            logic [2:0] rf;
            int r6;
            rf = 3'($urandom);
            r6 = int'($urandom % 6);
            request(rf);
            seq_body(rf, (r6 < 3) ? r6 : 3, bit'($urandom % 2), bit'($urandom % 4 == 0), 1'b0, 3'd0);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_P * WD_CYC);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule